// File: doc/BRIEF.md
# MESI Snooping Line State Controller

This block keeps the coherence state of every line in one processor's cache that sits on a shared snooping bus. Each line holds an address tag and one of four states: Modified, Exclusive, Shared or Invalid. The local processor presents read and write requests. The controller decides from the indexed line whether a bus transaction is needed, and it reports the state the line takes. On a read miss, a shared signal driven by the other caches selects between Exclusive and Shared. A write to an Exclusive line needs no bus traffic at all.

Bus events from other processors arrive on a separate snoop port, either as a read or as an intent to write. A snooped hit on a dirty line raises a writeback request so that the owner supplies its data. A local miss that displaces a dirty line raises an eviction request that carries the victim's full address. The block handles only tags and states. Data storage, arbitration and memory timing belong to the neighbouring blocks. All outputs are combinational from the stored state and the current inputs, and the line array updates on the next rising clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. States are encoded on the state outputs as Invalid=00, Shared=01, Exclusive=10, Modified=11. With no request on a port, that port's state output is 00, `bus_cmd` is 00, and no request flag is raised.
- R2: A local read that misses drives `bus_cmd`=01 (read miss). The line becomes Exclusive when `lcl_shared` is low and Shared when it is high, and it takes the new tag.
- R3: A local read that hits a Shared, Exclusive or Modified line drives `bus_cmd`=00 and leaves the state unchanged.
- R4: A local write that finds the line Invalid drives `bus_cmd`=10 (write miss), and the line becomes Modified.
- R5: A local write that hits an Exclusive line makes it Modified with `bus_cmd`=00.
- R6: A local write that hits a Shared line drives `bus_cmd`=11 (intent to write) and makes it Modified.
- R7: A local write that hits a Modified line keeps it Modified with `bus_cmd`=00.
- R8: A snooped read (`snp_intent`=0) that hits a Modified line raises `snp_wb_req` and moves the line to Shared. A hit on an Exclusive line moves it to Shared. A hit on a Shared line stays Shared. Neither of the last two raises `snp_wb_req`.
- R9: A snooped intent to write (`snp_intent`=1) that hits moves the line to Invalid. It raises `snp_wb_req` only when the line was Modified.
- R10: A line whose stored tag differs from the address behaves as Invalid. A snoop to such an address reports 00, raises no writeback and leaves the stored line untouched. A local access to such an address is a miss.
- R11: When local and snoop requests address the same index in one cycle, the snoop is applied and `lcl_stall` is 1. The local request then issues no bus command and no eviction and changes no state, and `lcl_nxt_state` shows the line's current state. The request may be retried.
- R12: A local miss accepted on an index that holds a Modified line with another tag raises `evict_req`, and `evict_addr` gives that line's old tag concatenated with the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request present |
| lcl_write | input | 1 | 1 = write, 0 = read |
| lcl_addr | input | ADDR_W | Local line address (low IDX_W bits index) |
| lcl_shared | input | 1 | Shared signal sampled on a read miss |
| snp_valid | input | 1 | Snooped bus event present |
| snp_intent | input | 1 | 1 = intent to write, 0 = read |
| snp_addr | input | ADDR_W | Snooped line address |
| lcl_stall | output | 1 | Local request held back by a same-index snoop |
| lcl_nxt_state | output | 2 | Next state of the local line |
| bus_cmd | output | 2 | 00 none, 01 read miss, 10 write miss, 11 intent to write |
| evict_req | output | 1 | Dirty victim must be written back |
| evict_addr | output | ADDR_W | Address of the dirty victim |
| snp_nxt_state | output | 2 | Next state of the snooped line |
| snp_wb_req | output | 1 | Dirty data must be supplied for the snoop |

## Verification
A line stored with the wrong state shows up on the next access to its address. A wrong value shows up as the wrong bus command or as a missing or extra writeback. A stale Exclusive that should be Shared turns a needed intent-to-write into silence. Corruption of the tag shows up as a spurious miss or eviction one cycle after the bad update. For this reason the sweep follows every write with later accesses, from both ports, that land on the same indices.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_st_e;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_RD_MISS = 2'b01,
    CMD_WR_MISS = 2'b10,
    CMD_UPGRADE = 2'b11
  } bus_cmd_e;

  // state after an accepted local access; cur is already tag-qualified
  function automatic mesi_st_e lcl_next(mesi_st_e cur, logic wr, logic shared);
    if (wr) return ST_M;
    if (cur == ST_I) return shared ? ST_S : ST_E;
    return cur;
  endfunction

  // bus command an accepted local access needs
  function automatic bus_cmd_e lcl_cmd(mesi_st_e cur, logic wr);
    if (wr) begin
      case (cur)
        ST_I:    return CMD_WR_MISS;
        ST_S:    return CMD_UPGRADE;
        default: return CMD_NONE;
      endcase
    end
    return (cur == ST_I) ? CMD_RD_MISS : CMD_NONE;
  endfunction

  // state after a snooped event; cur is already tag-qualified
  function automatic mesi_st_e snp_next(mesi_st_e cur, logic intent);
    if (cur == ST_I) return ST_I;
    return intent ? ST_I : ST_S;
  endfunction

  function automatic logic is_dirty(mesi_st_e cur);
    return cur == ST_M;
  endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_line_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output mesi_st_e         a_st,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output mesi_st_e         b_st,
  output logic [TAG_W-1:0] b_tag,
  input  logic             lcl_we,
  input  logic [IDX_W-1:0] lcl_widx,
  input  mesi_st_e         lcl_wst,
  input  logic [TAG_W-1:0] lcl_wtag,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_widx,
  input  mesi_st_e         snp_wst
);
  localparam int NUM_LINES = 1 << IDX_W;

  logic [NUM_LINES*2-1:0]     st_vec;
  logic [NUM_LINES*TAG_W-1:0] tag_vec;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    mesi_st_e         st_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= ST_I;
        tag_q <= '0;
      end else begin
        if (lcl_we && lcl_widx == MY_IDX) begin
          st_q  <= lcl_wst;
          tag_q <= lcl_wtag;
        end
        // snoop writes last so it wins on a shared index
        if (snp_we && snp_widx == MY_IDX) st_q <= snp_wst;
      end
    end

    assign st_vec[g*2 +: 2]          = st_q;
    assign tag_vec[g*TAG_W +: TAG_W] = tag_q;
  end

  assign a_st  = mesi_st_e'(st_vec[int'(a_idx)*2 +: 2]);
  assign a_tag = tag_vec[int'(a_idx)*TAG_W +: TAG_W];
  assign b_st  = mesi_st_e'(st_vec[int'(b_idx)*2 +: 2]);
  assign b_tag = tag_vec[int'(b_idx)*TAG_W +: TAG_W];

endmodule

// File: rtl/mesi_lcl_fsm.sv
module mesi_lcl_fsm
  import mesi_line_pkg::*;
(
  input  logic     req,
  input  logic     wr,
  input  logic     shared,
  input  logic     blocked,
  input  mesi_st_e raw_st,
  input  logic     tag_match,
  output logic     hit,
  output mesi_st_e cur_st,
  output mesi_st_e nxt_st,
  output bus_cmd_e cmd,
  output logic     stall,
  output logic     evict,
  output logic     we
);
  logic accept;

  assign hit    = tag_match && (raw_st != ST_I);
  assign cur_st = hit ? raw_st : ST_I;
  assign accept = req && !blocked;
  assign stall  = req && blocked;
  assign we     = accept;
  assign evict  = accept && !hit && is_dirty(raw_st);

  always_comb begin
    nxt_st = ST_I;
    cmd    = CMD_NONE;
    if (accept) begin
      nxt_st = lcl_next(cur_st, wr, shared);
      cmd    = lcl_cmd(cur_st, wr);
    end else if (stall) begin
      nxt_st = cur_st;
    end
  end

endmodule

// File: rtl/mesi_snp_fsm.sv
module mesi_snp_fsm
  import mesi_line_pkg::*;
(
  input  logic     req,
  input  logic     intent,
  input  mesi_st_e raw_st,
  input  logic     tag_match,
  output logic     hit,
  output mesi_st_e cur_st,
  output mesi_st_e nxt_st,
  output logic     supply,
  output logic     we
);
  assign hit    = req && tag_match && (raw_st != ST_I);
  assign cur_st = hit ? raw_st : ST_I;
  assign nxt_st = hit ? snp_next(cur_st, intent) : ST_I;
  assign supply = hit && is_dirty(cur_st);
  assign we     = hit;

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_line_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_valid,
  input  logic              lcl_write,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic              lcl_shared,
  input  logic              snp_valid,
  input  logic              snp_intent,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              lcl_stall,
  output logic [1:0]        lcl_nxt_state,
  output logic [1:0]        bus_cmd,
  output logic              evict_req,
  output logic [ADDR_W-1:0] evict_addr,
  output logic [1:0]        snp_nxt_state,
  output logic              snp_wb_req
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] lcl_idx, snp_idx;
  logic [TAG_W-1:0] lcl_tag, snp_tag;
  assign lcl_idx = lcl_addr[IDX_W-1:0];
  assign lcl_tag = lcl_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  // named internal events, observed by the bound checker
  mesi_st_e         lcl_raw_st, snp_raw_st;
  logic [TAG_W-1:0] lcl_old_tag, snp_old_tag;
  logic             lcl_conflict, lcl_hit, snp_hit, lcl_we, snp_we;
  mesi_st_e         lcl_cur_st, snp_cur_st, lcl_nxt, snp_nxt;
  bus_cmd_e         cmd;

  assign lcl_conflict = lcl_valid && snp_valid && (lcl_idx == snp_idx);

  mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) array_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (lcl_idx),
    .a_st     (lcl_raw_st),
    .a_tag    (lcl_old_tag),
    .b_idx    (snp_idx),
    .b_st     (snp_raw_st),
    .b_tag    (snp_old_tag),
    .lcl_we   (lcl_we),
    .lcl_widx (lcl_idx),
    .lcl_wst  (lcl_nxt),
    .lcl_wtag (lcl_tag),
    .snp_we   (snp_we),
    .snp_widx (snp_idx),
    .snp_wst  (snp_nxt)
  );

  mesi_lcl_fsm lcl_i (
    .req       (lcl_valid),
    .wr        (lcl_write),
    .shared    (lcl_shared),
    .blocked   (lcl_conflict),
    .raw_st    (lcl_raw_st),
    .tag_match (lcl_old_tag == lcl_tag),
    .hit       (lcl_hit),
    .cur_st    (lcl_cur_st),
    .nxt_st    (lcl_nxt),
    .cmd       (cmd),
    .stall     (lcl_stall),
    .evict     (evict_req),
    .we        (lcl_we)
  );

  mesi_snp_fsm snp_i (
    .req       (snp_valid),
    .intent    (snp_intent),
    .raw_st    (snp_raw_st),
    .tag_match (snp_old_tag == snp_tag),
    .hit       (snp_hit),
    .cur_st    (snp_cur_st),
    .nxt_st    (snp_nxt),
    .supply    (snp_wb_req),
    .we        (snp_we)
  );

  assign lcl_nxt_state = lcl_nxt;
  assign snp_nxt_state = snp_nxt;
  assign bus_cmd       = cmd;
  assign evict_addr    = {lcl_old_tag, lcl_idx};

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
  import mesi_line_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lcl_valid,
  input logic              lcl_write,
  input logic [ADDR_W-1:0] lcl_addr,
  input logic              snp_valid,
  input logic              snp_intent,
  input logic              lcl_stall,
  input logic [1:0]        bus_cmd,
  input logic              evict_req,
  input logic [1:0]        lcl_nxt_state,
  input logic [1:0]        snp_nxt_state,
  input logic              snp_wb_req,
  input logic              lcl_hit,
  input logic              snp_hit,
  input mesi_st_e          lcl_cur_st,
  input mesi_st_e          snp_cur_st
);

  // R5: exclusive line is written without bus traffic
  a_r5_silent_excl: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_valid && lcl_write && !lcl_stall && lcl_cur_st == ST_E
    |-> bus_cmd == CMD_NONE && lcl_nxt_state == ST_M);

  // R6: shared line upgrade announces intent to write
  a_r6_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_valid && lcl_write && !lcl_stall && lcl_cur_st == ST_S
    |-> bus_cmd == CMD_UPGRADE);

  // R4: an accepted write leaves the line Modified for the next access
  a_r4_write_lands_m: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_valid && $past(lcl_valid && lcl_write && !lcl_stall) &&
    $stable(lcl_addr) && !$past(snp_valid)
    |-> lcl_hit && lcl_cur_st == ST_M);

  // R8: snooped read of a dirty line supplies data and shares
  a_r8_snp_rd_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_intent && snp_hit && snp_cur_st == ST_M
    |-> snp_wb_req && snp_nxt_state == ST_S);

  // R8: writeback only ever for a dirty snoop hit
  a_r8_wb_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb_req |-> snp_hit && snp_cur_st == ST_M);

  // R9: intent to write from elsewhere invalidates
  a_r9_snp_inval: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_intent && snp_hit |-> snp_nxt_state == ST_I);

  // R11: a stalled request stays off the bus
  a_r11_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_stall |-> bus_cmd == CMD_NONE && !evict_req);

  // R1: bus is quiet without a local request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lcl_valid |-> bus_cmd == CMD_NONE && !lcl_stall && !evict_req);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .lcl_valid     (lcl_valid),
  .lcl_write     (lcl_write),
  .lcl_addr      (lcl_addr),
  .snp_valid     (snp_valid),
  .snp_intent    (snp_intent),
  .lcl_stall     (lcl_stall),
  .bus_cmd       (bus_cmd),
  .evict_req     (evict_req),
  .lcl_nxt_state (lcl_nxt_state),
  .snp_nxt_state (snp_nxt_state),
  .snp_wb_req    (snp_wb_req),
  .lcl_hit       (lcl_hit),
  .snp_hit       (snp_hit),
  .lcl_cur_st    (lcl_cur_st),
  .snp_cur_st    (snp_cur_st)
);

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;
  localparam int AW = 4;
  localparam int IW = 2;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lcl_valid = 1'b0, lcl_write = 1'b0, lcl_shared = 1'b0;
  logic          snp_valid = 1'b0, snp_intent = 1'b0;
  logic [AW-1:0] lcl_addr = '0, snp_addr = '0;
  logic          lcl_stall, evict_req, snp_wb_req;
  logic [1:0]    lcl_nxt_state, bus_cmd, snp_nxt_state;
  logic [AW-1:0] evict_addr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // bench model of the line array
  logic [1:0] m_st [NL];
  logic [1:0] m_tag[NL];

  always #5 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .lcl_valid     (lcl_valid),
    .lcl_write     (lcl_write),
    .lcl_addr      (lcl_addr),
    .lcl_shared    (lcl_shared),
    .snp_valid     (snp_valid),
    .snp_intent    (snp_intent),
    .snp_addr      (snp_addr),
    .lcl_stall     (lcl_stall),
    .lcl_nxt_state (lcl_nxt_state),
    .bus_cmd       (bus_cmd),
    .evict_req     (evict_req),
    .evict_addr    (evict_addr),
    .snp_nxt_state (snp_nxt_state),
    .snp_wb_req    (snp_wb_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic lv, input logic lw, input logic [AW-1:0] la,
                       input logic sh, input logic sv, input logic si,
                       input logic [AW-1:0] sa);
    logic [IW-1:0] li, sx;
    logic [1:0] lt, stg, l_raw, l_cur, e_nxt, e_cmd, e_snp;
    logic conflict, s_hit, l_hit, e_stall, e_ev, e_wb;
    string lreq, sreq;
    @(negedge clk);
    lcl_valid = lv; lcl_write = lw; lcl_addr = la; lcl_shared = sh;
    snp_valid = sv; snp_intent = si; snp_addr = sa;
    #4;
    li = la[IW-1:0]; lt = la[AW-1:IW];
    sx = sa[IW-1:0]; stg = sa[AW-1:IW];
    conflict = lv && sv && (li == sx);
    // snoop side
    s_hit = sv && m_st[sx] != 2'd0 && m_tag[sx] == stg;
    e_snp = !s_hit ? 2'd0 : (si ? 2'd0 : 2'd1);
    e_wb  = s_hit && m_st[sx] == 2'd3;
    sreq  = !s_hit ? "R10" : (si ? "R9" : "R8");
    if (!sv) sreq = "R1";
    // local side
    l_raw = m_st[li];
    l_hit = l_raw != 2'd0 && m_tag[li] == lt;
    l_cur = l_hit ? l_raw : 2'd0;
    e_nxt = 2'd0; e_cmd = 2'd0; e_stall = 1'b0; e_ev = 1'b0;
    if (!lv) lreq = "R1";
    else if (conflict) begin
      lreq = "R11"; e_stall = 1'b1; e_nxt = l_cur;
    end else begin
      e_ev = !l_hit && l_raw == 2'd3;
      if (!lw) begin
        e_cmd = (l_cur == 2'd0) ? 2'd1 : 2'd0;
        e_nxt = (l_cur == 2'd0) ? (sh ? 2'd1 : 2'd2) : l_cur;
        lreq  = (l_cur == 2'd0) ? "R2" : "R3";
      end else begin
        e_cmd = (l_cur == 2'd0) ? 2'd2 : ((l_cur == 2'd1) ? 2'd3 : 2'd0);
        e_nxt = 2'd3;
        case (l_cur)
          2'd0: lreq = (l_raw != 2'd0) ? "R10" : "R4";
          2'd1: lreq = "R6";
          2'd2: lreq = "R5";
          default: lreq = "R7";
        endcase
      end
    end
    chk(lreq, "lcl_nxt_state", int'(lcl_nxt_state), int'(e_nxt));
    chk(lreq, "bus_cmd", int'(bus_cmd), int'(e_cmd));
    chk(lreq, "lcl_stall", int'(lcl_stall), int'(e_stall));
    chk(e_ev ? "R12" : lreq, "evict_req", int'(evict_req), int'(e_ev));
    if (e_ev) chk("R12", "evict_addr", int'(evict_addr), int'({m_tag[li], li}));
    chk(sreq, "snp_nxt_state", int'(snp_nxt_state), int'(e_snp));
    chk(sreq, "snp_wb_req", int'(snp_wb_req), int'(e_wb));
    // model update at the coming edge; snoop has priority on a shared index
    if (lv && !conflict) begin m_st[li] = e_nxt; m_tag[li] = lt; end
    if (s_hit) m_st[sx] = e_snp;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = 2'd0; m_tag[i] = 2'd0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state is quiet on every output
    #4;
    chk("R1", "lcl_nxt_state", int'(lcl_nxt_state), 0);
    chk("R1", "bus_cmd", int'(bus_cmd), 0);
    chk("R1", "snp_wb_req", int'(snp_wb_req), 0);
    chk("R1", "lcl_stall", int'(lcl_stall), 0);
    // R1/R2: every line starts Invalid, so first reads miss
    for (int a = 0; a < NL; a++) apply(1'b1, 1'b0, AW'(a), 1'b0, 1'b0, 1'b0, '0);
    // R5/R3: write to Exclusive is silent, then read hit keeps Modified
    apply(1'b1, 1'b1, AW'(1), 1'b0, 1'b0, 1'b0, '0);
    apply(1'b1, 1'b0, AW'(1), 1'b0, 1'b0, 1'b0, '0);
    // R8 then R6: snoop read shares the dirty line, local write upgrades
    apply(1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, AW'(1));
    apply(1'b1, 1'b1, AW'(1), 1'b0, 1'b0, 1'b0, '0);
    // R12: miss on a dirty index with another tag evicts
    apply(1'b1, 1'b0, AW'(5), 1'b1, 1'b0, 1'b0, '0);
    // R11: same-index collision stalls local, snoop applied
    apply(1'b1, 1'b1, AW'(5), 1'b0, 1'b1, 1'b1, AW'(5));
    // near-exhaustive sweep of every input combination, scrambled order
    for (int pass = 0; pass < 3; pass++) begin
      for (int k = 0; k < 8192; k++) begin
        logic [12:0] c;
        c = 13'((k * 5039 + pass * 77) % 8192);
        apply(c[0], c[1], c[5:2], c[6], c[7], c[8], c[12:9]);
      end
    end
    @(negedge clk);
    lcl_valid = 1'b0; snp_valid = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule